// File: doc/BRIEF.md
# Source-Chain DMA Tag Walker

This block walks a linked list of 64-bit transfer tags that sit in memory for one source-chain channel. It is started with the address of the first tag. It fetches each tag through a simple request/response read port and decodes it. For each tag it emits one transfer descriptor, made of a memory address and a quadword count, and then works out where the next tag lives. A tag holds a 32-bit address in bits 63:32 and a command word in bits 31:0. In the command word, bit 31 asks for an interrupt, bits 30:28 give the tag type, bits 27:26 carry a priority hint and bits 15:0 give the quadword count Q. One quadword is 16 bytes.

Subroutine-style lists are supported through a small hardware return-address stack. It has two entries by default. The walk ends on a terminating tag type, or on a return with nothing pushed. A walk also stops on an error, and no descriptor is emitted for the tag that caused the error. The data itself is moved by a separate engine that consumes the descriptors. The upper half of the last command word fetched is held for software to read.

In the requirements below, T is the current tag address, A is the tag's address field and Q is its count.

Top module: `chain_tag_walker`

## Requirements
- R1: After `start`, the block issues exactly one read per tag, with `rd_addr` equal to that tag's address. It holds `rd_req` until `rd_valid` and captures `rd_data` in that cycle.
- R2: Type 1 (inline count) emits a descriptor (T+16, Q), and the next tag is at T+16+16·Q.
- R3: Type 2 (jump) emits (T+16, Q), and the next tag is at A.
- R4: Types 3 and 4 (by reference) emit (A, Q), and the next tag is at T+16.
- R5: Type 0 emits (A, Q) and ends the walk. Type 7 emits (T+16, Q) and ends the walk. A normal end gives a one-cycle `done` pulse with `err_code` 0, and `busy` then falls.
- R6: Type 5 (subroutine entry) emits (T+16, Q), pushes T+16+16·Q and continues at A. Type 6 (return) emits (T+16, Q) and continues at the most recent pushed address, which it pops. With nothing pushed, type 6 ends the walk. `stack_level` shows the number of pushed entries.
- R7: Type 5 with two entries already pushed emits no descriptor, sets `err_code` 3 and halts without `done`.
- R8: A tag address with any of bits 3:0 set stops the walk before any read of that address. It sets `err_code` 1 and emits no descriptor.
- R9: A tag whose type bit in `id_allow` is 0 emits no descriptor, sets `err_code` 2 and halts.
- R10: `tag_irq` pulses together with a tag's descriptor only when command bit 31 and `irq_en` are both 1.
- R11: `tag_status` holds bits 31:16 of the most recently fetched command word, including one that is then rejected.
- R12: After reset, `busy`, `rd_req`, `desc_valid`, `done`, `tag_irq`, `err_code` and `stack_level` are all 0. A new `start` clears `err_code` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk; taken only when idle |
| start_addr | input | 32 | Address of the first tag |
| irq_en | input | 1 | Channel tag-interrupt enable |
| id_allow | input | 8 | Bit n set: tag type n is accepted on this channel |
| rd_req | output | 1 | Tag read request, held until response |
| rd_addr | output | 32 | Tag read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 64 | Read response: the 64-bit tag |
| desc_valid | output | 1 | One-cycle descriptor strobe |
| desc_addr | output | 32 | Descriptor memory address |
| desc_qwc | output | 16 | Descriptor quadword count |
| tag_irq | output | 1 | One-cycle tag interrupt pulse |
| done | output | 1 | One-cycle pulse on normal end of walk |
| busy | output | 1 | A walk is in progress |
| err_code | output | 2 | 0 none, 1 misaligned tag, 2 type not allowed, 3 stack overflow |
| stack_level | output | 2 | Number of pushed return addresses |
| tag_status | output | 16 | Bits 31:16 of the last fetched command |

## Verification
The first pattern is a linear list that mixes inline, jump and by-reference tags and ends on a terminating tag. It separates the three address rules, because each one sends the next fetch to a different place. A nested subroutine list, with two entries, two returns and a final return on an empty stack, shows last-in first-out ordering and the empty-stack end. A third call pushed onto a full stack shows the overflow halt. Single-tag walks with a misaligned start, a misaligned jump target, a disallowed type and the interrupt enable cleared tell apart each error code, and show that the interrupt gating and the status capture behave as required.

// File: rtl/walker_pkg.sv
// Shared types for the source-chain tag walker.
// Assumes a 64-bit tag: bits 63:32 address, bits 31:0 command.
package walker_pkg;
    localparam int TAG_W    = 64;
    localparam int TADDR_W  = 32;
    localparam int QWC_W    = 16;
    localparam int QW_SHIFT = 4;

    typedef enum logic [2:0] {
        ID_REFE = 3'd0,
        ID_CNT  = 3'd1,
        ID_NEXT = 3'd2,
        ID_REF  = 3'd3,
        ID_REFS = 3'd4,
        ID_CALL = 3'd5,
        ID_RET  = 3'd6,
        ID_END  = 3'd7
    } tag_id_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_ALIGN = 2'd1,
        ERR_ID    = 2'd2,
        ERR_STACK = 2'd3
    } walk_err_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/addr_stack.sv
// Return-address stack for subroutine tags.
// Assumes the caller never pushes when full or pops when empty;
// push and pop are never requested together. clear wins over both.
module addr_stack #(
    parameter int DEPTH = 2,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [PW-1:0] level,
    output logic [AW-1:0] top
);
    logic [AW-1:0] ent [DEPTH];

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) level <= '0;
        else if (push)       level <= level + PW'(1);
        else if (pop)        level <= level - PW'(1);
    end

    // One storage register per stage, written when it is the next free slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)                            ent[i] <= '0;
            else if (push && level == PW'(i))      ent[i] <= push_addr;
        end
    end

    // Select the most recently pushed entry.
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (level == PW'(i + 1)) top = ent[i];
    end

    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> level < PW'(DEPTH));
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> level != '0);
    a_r6_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |=> top == $past(push_addr));
endmodule

// File: rtl/tag_decode.sv
// Combinational tag decoder: from the current tag address, the tag and
// the stack state, produce the descriptor, the next tag address and the
// stack action. Assumes tag_ptr is quadword aligned.
module tag_decode
    import walker_pkg::*;
#(
    parameter int STACK_DEPTH = 2,
    localparam int PW = $clog2(STACK_DEPTH + 1)
) (
    input  logic [TADDR_W-1:0] tag_ptr,
    input  logic [TAG_W-1:0]   tag,
    input  logic [7:0]         id_allow,
    input  logic [PW-1:0]      level,
    input  logic [TADDR_W-1:0] top,
    output logic               emit,
    output logic [TADDR_W-1:0] d_addr,
    output logic [QWC_W-1:0]   d_qwc,
    output logic [TADDR_W-1:0] next_ptr,
    output logic               finish,
    output logic               push,
    output logic               pop,
    output logic [TADDR_W-1:0] push_addr,
    output logic               fault,
    output walk_err_e          fault_code
);
    tag_id_e            id;
    logic [TADDR_W-1:0] field_addr;
    logic [TADDR_W-1:0] inline_addr;
    logic [TADDR_W-1:0] after_addr;

    // Field extraction and the two derived addresses.
    always_comb begin
        id          = tag_id_e'(tag[30:28]);
        field_addr  = tag[63:32];
        d_qwc       = tag[QWC_W-1:0];
        inline_addr = tag_ptr + TADDR_W'(16);
        after_addr  = inline_addr + (TADDR_W'(tag[QWC_W-1:0]) << QW_SHIFT);
    end

    // Per-type action selection.
    always_comb begin
        emit       = 1'b1;
        d_addr     = inline_addr;
        next_ptr   = after_addr;
        finish     = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        push_addr  = after_addr;
        fault      = 1'b0;
        fault_code = ERR_NONE;
        if (!id_allow[id]) begin
            emit       = 1'b0;
            fault      = 1'b1;
            fault_code = ERR_ID;
        end else begin
            unique case (id)
                ID_REFE: begin
                    d_addr = field_addr;
                    finish = 1'b1;
                end
                ID_CNT: ;
                ID_NEXT: next_ptr = field_addr;
                ID_REF, ID_REFS: begin
                    d_addr   = field_addr;
                    next_ptr = inline_addr;
                end
                ID_CALL: begin
                    if (level == PW'(STACK_DEPTH)) begin
                        emit       = 1'b0;
                        fault      = 1'b1;
                        fault_code = ERR_STACK;
                    end else begin
                        push     = 1'b1;
                        next_ptr = field_addr;
                    end
                end
                ID_RET: begin
                    if (level == '0) finish = 1'b1;
                    else begin
                        pop      = 1'b1;
                        next_ptr = top;
                    end
                end
                ID_END: finish = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/chain_tag_walker.sv
// Source-chain tag walker top: sequences fetch -> decode -> descriptor
// for each tag until an end condition or an error.
// Assumes one outstanding read; rd_valid comes only while rd_req is high.
module chain_tag_walker
    import walker_pkg::*;
#(
    parameter int STACK_DEPTH = 2,
    localparam int PW = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [TADDR_W-1:0] start_addr,
    input  logic               irq_en,
    input  logic [7:0]         id_allow,
    output logic               rd_req,
    output logic [TADDR_W-1:0] rd_addr,
    input  logic               rd_valid,
    input  logic [TAG_W-1:0]   rd_data,
    output logic               desc_valid,
    output logic [TADDR_W-1:0] desc_addr,
    output logic [QWC_W-1:0]   desc_qwc,
    output logic               tag_irq,
    output logic               done,
    output logic               busy,
    output logic [1:0]         err_code,
    output logic [PW-1:0]      stack_level,
    output logic [15:0]        tag_status
);
    walk_state_e        state;
    logic [TADDR_W-1:0] tag_ptr;
    logic [TAG_W-1:0]   tag_q;
    walk_err_e          err_q;
    logic               misaligned;

    logic               dec_emit, dec_finish, dec_push, dec_pop, dec_fault;
    logic [TADDR_W-1:0] dec_next, dec_push_addr, stk_top;
    walk_err_e          dec_code;
    logic               in_exec, stk_clear;

    assign misaligned = tag_ptr[QW_SHIFT-1:0] != '0;
    assign in_exec    = state == ST_EXEC;
    assign stk_clear  = state == ST_IDLE && start;

    tag_decode #(.STACK_DEPTH(STACK_DEPTH)) u_dec (
        .tag_ptr   (tag_ptr),
        .tag       (tag_q),
        .id_allow  (id_allow),
        .level     (stack_level),
        .top       (stk_top),
        .emit      (dec_emit),
        .d_addr    (desc_addr),
        .d_qwc     (desc_qwc),
        .next_ptr  (dec_next),
        .finish    (dec_finish),
        .push      (dec_push),
        .pop       (dec_pop),
        .push_addr (dec_push_addr),
        .fault     (dec_fault),
        .fault_code(dec_code)
    );

    addr_stack #(.DEPTH(STACK_DEPTH), .AW(TADDR_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stk_clear),
        .push     (in_exec && dec_push),
        .pop      (in_exec && dec_pop),
        .push_addr(dec_push_addr),
        .level    (stack_level),
        .top      (stk_top)
    );

    // Walk sequencer: idle, fetch a tag, execute it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tag_ptr    <= '0;
            tag_q      <= '0;
            err_q      <= ERR_NONE;
            tag_status <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    tag_ptr <= start_addr;
                    err_q   <= ERR_NONE;
                    state   <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (misaligned) begin
                        err_q <= ERR_ALIGN;
                        state <= ST_IDLE;
                    end else if (rd_valid) begin
                        tag_q      <= rd_data;
                        tag_status <= rd_data[31:16];
                        state      <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (dec_fault) begin
                        err_q <= dec_code;
                        state <= ST_IDLE;
                    end else if (dec_finish) begin
                        state <= ST_IDLE;
                    end else begin
                        tag_ptr <= dec_next;
                        state   <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output strobes derived from the current state.
    always_comb begin
        rd_req     = state == ST_FETCH && !misaligned;
        rd_addr    = tag_ptr;
        desc_valid = in_exec && dec_emit;
        tag_irq    = desc_valid && tag_q[31] && irq_en;
        done       = in_exec && !dec_fault && dec_finish;
        busy       = state != ST_IDLE;
        err_code   = err_q;
    end

    a_r8_misalign_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && misaligned) |=> (!busy && err_code == 2'd1));
    a_r1_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (!rd_req && in_exec));
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tag_irq |-> (desc_valid && irq_en));
    a_r5_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r11_status_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> tag_status == $past(rd_data[31:16]));
    a_r7_no_desc_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && dec_fault) |-> !desc_valid);
endmodule

// File: tb/chain_tag_walker_tb_top.sv
`timescale 1ns/1ps
module chain_tag_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        irq_en = 1'b0;
    logic [7:0]  id_allow = 8'hFF;
    logic        rd_req, rd_valid;
    logic [31:0] rd_addr;
    logic [63:0] rd_data;
    logic        desc_valid, tag_irq, done, busy;
    logic [31:0] desc_addr;
    logic [15:0] desc_qwc, tag_status;
    logic [1:0]  err_code, stack_level;

    int checks = 0;
    int fails  = 0;

    logic [63:0] mem [0:255];
    logic [31:0] f_log [0:31];
    logic [31:0] da_log [0:31];
    logic [15:0] dq_log [0:31];
    int f_n, d_n, irq_n, done_n;

    always #2 clk = ~clk;

    chain_tag_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .irq_en(irq_en), .id_allow(id_allow), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .desc_valid(desc_valid),
        .desc_addr(desc_addr), .desc_qwc(desc_qwc), .tag_irq(tag_irq), .done(done),
        .busy(busy), .err_code(err_code), .stack_level(stack_level),
        .tag_status(tag_status)
    );

    // Memory model: one-cycle read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req && !rd_valid;
            rd_data  <= mem[rd_addr[11:4]];
        end
    end

    // Observation away from the active edge.
    always @(negedge clk) begin
        if (rd_req && rd_valid && f_n < 32) begin f_log[f_n] = rd_addr; f_n++; end
        if (desc_valid && d_n < 32) begin
            da_log[d_n] = desc_addr; dq_log[d_n] = desc_qwc; d_n++;
        end
        if (tag_irq) irq_n++;
        if (done) done_n++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [63:0] mk(input logic [2:0] id, input logic irq,
                                       input logic [15:0] q, input logic [31:0] a);
        return {a, irq, id, 2'b00, 10'd0, q};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [63:0] t);
        mem[a[11:4]] = t;
    endtask

    task automatic run(input logic [31:0] sa);
        @(negedge clk);
        f_n = 0; d_n = 0; irq_n = 0; done_n = 0;
        start_addr = sa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R12 busy", 32'(busy), 0);
        chk("R12 rd_req", 32'(rd_req), 0);
        chk("R12 desc_valid", 32'(desc_valid), 0);
        chk("R12 done/irq", 32'({done, tag_irq}), 0);
        chk("R12 err_code", 32'(err_code), 0);
        chk("R12 stack_level", 32'(stack_level), 0);
    endtask

    task automatic t_linear;
        put(32'h100, mk(3'd1, 0, 16'd2, 32'h0));
        put(32'h130, mk(3'd2, 0, 16'd1, 32'h200));
        put(32'h200, mk(3'd3, 0, 16'd3, 32'h800));
        put(32'h210, mk(3'd4, 0, 16'd1, 32'h840));
        put(32'h220, mk(3'd7, 1, 16'd4, 32'h0));
        irq_en = 1'b1;
        run(32'h100);
        chk("R1 fetch count", f_n, 5);
        chk("R1 fetch0", f_log[0], 32'h100);
        chk("R2 fetch after inline data", f_log[1], 32'h130);
        chk("R3 jump target fetch", f_log[2], 32'h200);
        chk("R4 ref next fetch", f_log[3], 32'h210);
        chk("R4 refs next fetch", f_log[4], 32'h220);
        chk("R1 desc count", d_n, 5);
        chk("R2 cnt desc addr", da_log[0], 32'h110);
        chk("R2 cnt desc qwc", 32'(dq_log[0]), 2);
        chk("R3 next desc addr", da_log[1], 32'h140);
        chk("R4 ref desc addr", da_log[2], 32'h800);
        chk("R4 ref desc qwc", 32'(dq_log[2]), 3);
        chk("R4 refs desc addr", da_log[3], 32'h840);
        chk("R5 end desc addr", da_log[4], 32'h230);
        chk("R5 end desc qwc", 32'(dq_log[4]), 4);
        chk("R5 done pulses", done_n, 1);
        chk("R5 err_code", 32'(err_code), 0);
        chk("R10 irq count enabled", irq_n, 1);
        chk("R11 status", 32'(tag_status), 32'hF000);
    endtask

    task automatic t_callret;
        put(32'h300, mk(3'd5, 0, 16'd1, 32'h400));
        put(32'h400, mk(3'd5, 0, 16'd0, 32'h500));
        put(32'h500, mk(3'd6, 0, 16'd2, 32'h0));
        put(32'h410, mk(3'd6, 0, 16'd0, 32'h0));
        put(32'h320, mk(3'd6, 0, 16'd1, 32'h0));
        run(32'h300);
        chk("R6 fetch count", f_n, 5);
        chk("R6 call target", f_log[1], 32'h400);
        chk("R6 nested call target", f_log[2], 32'h500);
        chk("R6 pop inner", f_log[3], 32'h410);
        chk("R6 pop outer", f_log[4], 32'h320);
        chk("R6 call desc", da_log[0], 32'h310);
        chk("R6 ret desc", da_log[2], 32'h510);
        chk("R6 final ret desc", da_log[4], 32'h330);
        chk("R6 empty ret ends", done_n, 1);
        chk("R6 stack empty", 32'(stack_level), 0);
        chk("R6 err_code", 32'(err_code), 0);
    endtask

    task automatic t_overflow;
        put(32'h600, mk(3'd5, 0, 16'd0, 32'h700));
        put(32'h700, mk(3'd5, 0, 16'd0, 32'h780));
        put(32'h780, mk(3'd5, 0, 16'd0, 32'h600));
        run(32'h600);
        chk("R7 fetch count", f_n, 3);
        chk("R7 desc count", d_n, 2);
        chk("R7 err_code", 32'(err_code), 3);
        chk("R7 no done", done_n, 0);
        chk("R7 stack_level", 32'(stack_level), 2);
        chk("R7 halted", 32'(busy), 0);
    endtask

    task automatic t_refe_noirq;
        put(32'hA00, mk(3'd0, 1, 16'd5, 32'hC00));
        irq_en = 1'b0;
        run(32'hA00);
        chk("R12 err cleared by start", 32'(err_code), 0);
        chk("R5 refe desc addr", da_log[0], 32'hC00);
        chk("R5 refe desc qwc", 32'(dq_log[0]), 5);
        chk("R5 refe single fetch", f_n, 1);
        chk("R5 refe done", done_n, 1);
        chk("R10 irq masked", irq_n, 0);
    endtask

    task automatic t_misalign;
        run(32'h108);
        chk("R8 no read", f_n, 0);
        chk("R8 no desc", d_n, 0);
        chk("R8 err_code", 32'(err_code), 1);
        put(32'h900, mk(3'd2, 0, 16'd0, 32'h904));
        run(32'h900);
        chk("R8 one read", f_n, 1);
        chk("R8 jump desc", d_n, 1);
        chk("R8 err_code jump", 32'(err_code), 1);
        chk("R8 no done", done_n, 0);
    endtask

    task automatic t_disallow;
        put(32'hB00, mk(3'd1, 0, 16'd0, 32'h0));
        put(32'hB10, mk(3'd4, 0, 16'd9, 32'hD00));
        id_allow = 8'hEF;
        run(32'hB00);
        chk("R9 desc count", d_n, 1);
        chk("R9 err_code", 32'(err_code), 2);
        chk("R9 no done", done_n, 0);
        chk("R11 status of rejected tag", 32'(tag_status), 32'h4000);
        id_allow = 8'hFF;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        f_n = 0; d_n = 0; irq_n = 0; done_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_linear;
        t_callret;
        t_overflow;
        t_refe_noirq;
        t_misalign;
        t_disallow;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule